// File: doc/BRIEF.md
# Grouped Interrupt Request Controller

This block gathers twelve interrupt sources into a pending-request register, masks them with an enable register and drives four level interrupt lines toward a CPU. Several sources share a line. Source 0 has line 0 to itself, and source 1 has line 1. Sources 2 through 9 share line 2, and sources 10 and 11 share line 3. Requests come from three places: one-cycle set pulses on a generic per-source input, a scanline event decoder, and the expiry inputs of up to four countdown timers.

Software handles the block through two write strobes. One replaces the enable mask. The other ANDs a mask into the pending bits. A zero in that mask clears the bit, and it also acknowledges the bit's CPU line by pulling the line low for one cycle. The block reports the lowest-numbered source that is both enabled and pending, so the CPU services sources in index order. For each timer the block keeps a running flag. It ignores an expiry from a timer that is not running, and it pulses a reload request back to the timer on each valid expiry.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset, req_rd, en_rd, tmr_running, tmr_reload, irq_line, irq_src_id and irq_src_vld are all zero.
- R2: A cycle with line_valid=1 sets one request bit according to line_num: 384 sets bit 0, 0 sets bit 10, and 256 sets bit 2. Any other line number sets nothing, and so does line_valid=0. The bit reads back as 1 after the next clock edge.
- R3: tmr_start[n]=1 sets timer n running at the next edge. If tmr_expire[n]=1 while timer n is running, request bit n+2 is set, the running flag clears, and tmr_reload[n] is 1 for exactly one cycle. When start and expiry arrive in the same cycle, the start wins.
- R4: tmr_expire[n] while timer n is not running has no effect: no request bit is set and tmr_reload[n] stays 0.
- R5: en_wr=1 loads en_wdata into the enable register at the next edge, and en_rd reads it back.
- R6: req_wr=1 ANDs req_wdata into the pending bits. A 0 clears the bit and a 1 leaves it unchanged.
- R7: If a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: The registered value of irq_line[g] is the OR of (req & en) over the sources of group g: {0}, {1}, {2..9} and {10,11}. It follows the register state with one cycle of delay.
- R9: A request whose enable bit is 0 stays pending in req_rd and does not raise its line.
- R10: A request write with a 0 in any bit of a group forces that group's line low in the following cycle. The line then returns to the OR of what is still pending.
- R11: irq_src_id is the index of the lowest-numbered source that is both enabled and pending, and irq_src_vld is 1 when such a source exists. Both have the same one-cycle delay as irq_line. irq_src_id is 0 when irq_src_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_set | input | 12 | One-cycle set pulse per source |
| line_valid | input | 1 | Strobe: line_num is a new scanline |
| line_num | input | 10 | Current scanline number |
| tmr_start | input | 4 | Marks a timer running |
| tmr_expire | input | 4 | Timer expiry events |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 12 | New enable mask |
| req_wr | input | 1 | Request clear-write strobe |
| req_wdata | input | 12 | Mask ANDed into the pending bits |
| irq_line | output | 4 | CPU interrupt lines |
| irq_src_id | output | 4 | Lowest enabled pending source |
| irq_src_vld | output | 1 | irq_src_id is meaningful |
| req_rd | output | 12 | Pending-request register |
| en_rd | output | 12 | Enable register |
| tmr_running | output | 4 | Timer running flags |
| tmr_reload | output | 4 | Reload-to-all-ones pulse per timer |

## Verification
A pending or enable bit that is corrupted shows up directly on req_rd or en_rd after the next edge. One cycle after that it also shows on irq_line and irq_src_id, so any wrong state is visible within two cycles. A running flag that is wrong changes the outcome of the next expiry for that timer. The outcome is either a request that appears, or one that is missing, together with a reload pulse to match. The sweeps walk every scanline number, every pending pattern under a full enable mask and every single source. A long mixed run is compared cycle by cycle against a model built from the requirements.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned NUM_SRC   = 12;
   localparam int unsigned NUM_LINES = 4;
   localparam int unsigned ID_W      = $clog2(NUM_SRC);
   // fixed source positions used by the event decoders
   localparam int unsigned SRC_VBL   = 0;
   localparam int unsigned SRC_MID   = 2;
   localparam int unsigned SRC_TOP   = 10;
   localparam int unsigned TMR_BASE  = 2;

   // uneven fold of sources onto CPU lines
   function automatic int unsigned src_line(input int unsigned s);
      if (s == 0) return 0;
      if (s == 1) return 1;
      if (s <= 9) return 2;
      return 3;
   endfunction
endpackage

// File: rtl/irq_scan_decode.sv
module irq_scan_decode #(
   parameter int unsigned LINE_W   = 10,
   parameter int unsigned VBL_LINE = 384,
   parameter int unsigned TOP_LINE = 0,
   parameter int unsigned MID_LINE = 256
) (
   input  logic                        line_valid,
   input  logic [LINE_W-1:0]           line_num,
   output logic [irq_pkg::NUM_SRC-1:0] set_vec
);
   import irq_pkg::*;
   localparam logic [LINE_W-1:0] VBL_V = LINE_W'(VBL_LINE);
   localparam logic [LINE_W-1:0] TOP_V = LINE_W'(TOP_LINE);
   localparam logic [LINE_W-1:0] MID_V = LINE_W'(MID_LINE);

   if (VBL_LINE >= (1 << LINE_W) || MID_LINE >= (1 << LINE_W) || TOP_LINE >= (1 << LINE_W))
      $error("scanline constant does not fit LINE_W");

   always_comb begin
      set_vec = '0;
      if (line_valid) begin
         set_vec[SRC_VBL] = (line_num == VBL_V);
         set_vec[SRC_TOP] = (line_num == TOP_V);
         set_vec[SRC_MID] = (line_num == MID_V);
      end
   end
endmodule

// File: rtl/irq_timer_gate.sv
module irq_timer_gate #(
   parameter int unsigned NUM_TIMERS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_TIMERS-1:0]       start,
   input  logic [NUM_TIMERS-1:0]       expire,
   output logic [irq_pkg::NUM_SRC-1:0] set_vec,
   output logic [NUM_TIMERS-1:0]       running,
   output logic [NUM_TIMERS-1:0]       reload
);
   import irq_pkg::*;

   if (NUM_TIMERS < 1 || TMR_BASE + NUM_TIMERS > 10)
      $error("timers must map inside sources 2..9");

   logic [NUM_TIMERS-1:0] hit;

   for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_tmr
      assign hit[n] = expire[n] & running[n];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            running[n] <= 1'b0;
            reload[n]  <= 1'b0;
         end else begin
            running[n] <= start[n] | (running[n] & ~hit[n]);
            reload[n]  <= hit[n];
         end
      end

      // R3
      valid_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (expire[n] && running[n] && !start[n]) |=> (!running[n] && reload[n]));
      // R4
      idle_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (expire[n] && !running[n]) |=> !reload[n]);
   end

   always_comb begin
      set_vec = '0;
      for (int n = 0; n < NUM_TIMERS; n++) set_vec[TMR_BASE + n] = hit[n];
   end
endmodule

// File: rtl/irq_fold.sv
module irq_fold (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [irq_pkg::NUM_SRC-1:0]   active,
   input  logic [irq_pkg::NUM_SRC-1:0]   ack_src,
   output logic [irq_pkg::NUM_LINES-1:0] lines_q,
   output logic [irq_pkg::ID_W-1:0]      id_q,
   output logic                          vld_q
);
   import irq_pkg::*;

   logic [NUM_LINES-1:0] grp_or, grp_ack;
   logic [ID_W-1:0]      id_d;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_comb begin
         grp_or[g]  = 1'b0;
         grp_ack[g] = 1'b0;
         for (int s = 0; s < NUM_SRC; s++) begin
            if (src_line(s) == g) begin
               grp_or[g]  = grp_or[g]  | active[s];
               grp_ack[g] = grp_ack[g] | ack_src[s];
            end
         end
      end
   end

   // lowest index wins: scan from the top down
   always_comb begin
      id_d = '0;
      for (int s = NUM_SRC - 1; s >= 0; s--) begin
         if (active[s]) id_d = ID_W'(s);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lines_q <= '0;
         id_q    <= '0;
         vld_q   <= 1'b0;
      end else begin
         lines_q <= grp_or & ~grp_ack;
         id_q    <= id_d;
         vld_q   <= |active;
      end
   end

   // R8
   quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|active) |=> (lines_q == '0));
   // R11
   quiet_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|active) |=> (!vld_q && id_q == '0));
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_ack
      // R10
      ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ack_src[s] |=> !lines_q[src_line(s)]);
   end
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl #(
   parameter int unsigned LINE_W     = 10,
   parameter int unsigned NUM_TIMERS = 4,
   parameter int unsigned VBL_LINE   = 384,
   parameter int unsigned TOP_LINE   = 0,
   parameter int unsigned MID_LINE   = 256
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [irq_pkg::NUM_SRC-1:0]   ext_set,
   input  logic                          line_valid,
   input  logic [LINE_W-1:0]             line_num,
   input  logic [NUM_TIMERS-1:0]         tmr_start,
   input  logic [NUM_TIMERS-1:0]         tmr_expire,
   input  logic                          en_wr,
   input  logic [irq_pkg::NUM_SRC-1:0]   en_wdata,
   input  logic                          req_wr,
   input  logic [irq_pkg::NUM_SRC-1:0]   req_wdata,
   output logic [irq_pkg::NUM_LINES-1:0] irq_line,
   output logic [irq_pkg::ID_W-1:0]      irq_src_id,
   output logic                          irq_src_vld,
   output logic [irq_pkg::NUM_SRC-1:0]   req_rd,
   output logic [irq_pkg::NUM_SRC-1:0]   en_rd,
   output logic [NUM_TIMERS-1:0]         tmr_running,
   output logic [NUM_TIMERS-1:0]         tmr_reload
);
   import irq_pkg::*;

   logic [NUM_SRC-1:0] scan_set, tmr_set, all_set, keep_mask, ack_src;
   logic [NUM_SRC-1:0] req_q, en_q;

   irq_scan_decode #(
      .LINE_W(LINE_W), .VBL_LINE(VBL_LINE), .TOP_LINE(TOP_LINE), .MID_LINE(MID_LINE)
   ) i_scan (
      .line_valid(line_valid), .line_num(line_num), .set_vec(scan_set)
   );

   irq_timer_gate #(.NUM_TIMERS(NUM_TIMERS)) i_tmr (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .expire(tmr_expire),
      .set_vec(tmr_set), .running(tmr_running), .reload(tmr_reload)
   );

   assign all_set   = ext_set | scan_set | tmr_set;
   assign keep_mask = req_wr ? req_wdata : '1;
   assign ack_src   = ~keep_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= '0;
         en_q  <= '0;
      end else begin
         req_q <= (req_q & keep_mask) | all_set;
         if (en_wr) en_q <= en_wdata;
      end
   end

   irq_fold i_fold (
      .clk(clk), .rst_n(rst_n), .active(req_q & en_q), .ack_src(ack_src),
      .lines_q(irq_line), .id_q(irq_src_id), .vld_q(irq_src_vld)
   );

   assign req_rd = req_q;
   assign en_rd  = en_q;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_bit
      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         all_set[s] |=> req_q[s]);
      // R6
      and_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_wr && !req_wdata[s] && !all_set[s]) |=> !req_q[s]);
      // R6
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!all_set[s] && (!req_wr || req_wdata[s])) |=> (req_q[s] == $past(req_q[s])));
   end
   // R5
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> (en_q == $past(en_wdata)));
endmodule

// File: tb/test_irq_group_ctrl.sv
module test_irq_group_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [11:0] ext_set = '0, en_wdata = '0, req_wdata = '0;
   logic line_valid = 1'b0, en_wr = 1'b0, req_wr = 1'b0;
   logic [9:0] line_num = '0;
   logic [3:0] tmr_start = '0, tmr_expire = '0;
   logic [3:0] irq_line, irq_src_id, tmr_running, tmr_reload;
   logic irq_src_vld;
   logic [11:0] req_rd, en_rd;

   int checks = 0, errors = 0, cycles = 0;
   logic [11:0] m_req = '0, m_en = '0;
   logic [3:0]  m_run = '0, m_rel = '0, m_line = '0, m_id = '0;
   logic        m_vld = 1'b0;

   always #5 clk = ~clk;

   irq_group_ctrl i_irq_group_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_set(ext_set), .line_valid(line_valid),
      .line_num(line_num), .tmr_start(tmr_start), .tmr_expire(tmr_expire),
      .en_wr(en_wr), .en_wdata(en_wdata), .req_wr(req_wr), .req_wdata(req_wdata),
      .irq_line(irq_line), .irq_src_id(irq_src_id), .irq_src_vld(irq_src_vld),
      .req_rd(req_rd), .en_rd(en_rd), .tmr_running(tmr_running), .tmr_reload(tmr_reload)
   );

   function automatic logic [3:0] grp(input logic [11:0] p);
      return {|p[11:10], |p[9:2], p[1], p[0]};
   endfunction
   function automatic logic [3:0] lowest(input logic [11:0] p);
      for (int i = 0; i < 12; i++) if (p[i]) return 4'(i);
      return 4'd0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R6 req_rd", 32'(req_rd), 32'(m_req));
      chk("R5 en_rd", 32'(en_rd), 32'(m_en));
      chk("R3 tmr_running", 32'(tmr_running), 32'(m_run));
      chk("R3 tmr_reload", 32'(tmr_reload), 32'(m_rel));
      chk("R8 irq_line", 32'(irq_line), 32'(m_line));
      chk("R11 irq_src_id", 32'(irq_src_id), 32'(m_id));
      chk("R11 irq_src_vld", 32'(irq_src_vld), 32'(m_vld));
   endtask

   // one cycle: drive at negedge, model at posedge, compare at next negedge
   task automatic cyc(input logic [11:0] ext, input logic lv, input logic [9:0] ln,
                      input logic [3:0] st, input logic [3:0] ex,
                      input logic ew, input logic [11:0] ed,
                      input logic rw, input logic [11:0] rd);
      logic [11:0] setv, act, keep;
      logic [3:0] hit;
      ext_set = ext; line_valid = lv; line_num = ln; tmr_start = st; tmr_expire = ex;
      en_wr = ew; en_wdata = ed; req_wr = rw; req_wdata = rd;
      @(posedge clk);
      hit  = ex & m_run;
      setv = ext | {6'b0, hit, 2'b0};
      if (lv && ln == 10'd384) setv[0] = 1'b1;
      if (lv && ln == 10'd0)   setv[10] = 1'b1;
      if (lv && ln == 10'd256) setv[2] = 1'b1;
      keep = rw ? rd : 12'hFFF;
      act  = m_req & m_en;
      m_line = grp(act) & ~grp(~keep);
      m_id   = lowest(act);
      m_vld  = |act;
      m_rel  = hit;
      m_run  = st | (m_run & ~hit);
      m_req  = (m_req & keep) | setv;
      if (ew) m_en = ed;
      @(negedge clk);
      check_all();
   endtask

   task automatic idle();
      cyc('0, 1'b0, '0, '0, '0, 1'b0, '0, 1'b0, 12'hFFF);
   endtask
   task automatic clear_all();
      cyc('0, 1'b0, '0, '0, '0, 1'b0, '0, 1'b1, 12'h000);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [11:0] exp_bits;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 req", 32'(req_rd), 0); chk("R1 en", 32'(en_rd), 0);
      chk("R1 lines", 32'(irq_line), 0); chk("R1 run", 32'(tmr_running), 0);
      chk("R1 reload", 32'(tmr_reload), 0);
      chk("R1 id", 32'({irq_src_vld, irq_src_id}), 0);

      // R2 sweep every scanline number
      for (int ln = 0; ln < 1024; ln++) begin
         clear_all();
         cyc('0, 1'b1, 10'(ln), '0, '0, 1'b0, '0, 1'b0, 12'hFFF);
         exp_bits = (ln == 384) ? 12'h001 : (ln == 0) ? 12'h400 : (ln == 256) ? 12'h004 : 12'h000;
         chk("R2 scanline set", 32'(req_rd), 32'(exp_bits));
      end
      clear_all();
      cyc('0, 1'b0, 10'd384, '0, '0, 1'b0, '0, 1'b0, 12'hFFF);
      chk("R2 no strobe", 32'(req_rd), 0);

      // R4 expiry while idle
      cyc('0, 1'b0, '0, '0, 4'hF, 1'b0, '0, 1'b0, 12'hFFF);
      chk("R4 idle expiry req", 32'(req_rd), 0);
      chk("R4 idle expiry reload", 32'(tmr_reload), 0);
      // R3 each timer
      for (int n = 0; n < 4; n++) begin
         clear_all();
         cyc('0, 1'b0, '0, 4'(1 << n), '0, 1'b0, '0, 1'b0, 12'hFFF);
         chk("R3 started", 32'(tmr_running), 32'(1 << n));
         cyc('0, 1'b0, '0, '0, 4'(1 << n), 1'b0, '0, 1'b0, 12'hFFF);
         chk("R3 expiry bit", 32'(req_rd), 32'(1 << (n + 2)));
         chk("R3 reload pulse", 32'(tmr_reload), 32'(1 << n));
         chk("R3 stopped", 32'(tmr_running), 0);
         idle();
         chk("R3 reload one cycle", 32'(tmr_reload), 0);
      end

      // R7 set beats clear
      clear_all();
      cyc(12'h020, 1'b0, '0, '0, '0, 1'b0, '0, 1'b1, 12'h000);
      chk("R7 set wins", 32'(req_rd[5]), 1);

      // R9 disabled request stays pending, line stays low
      clear_all();
      cyc(12'h002, 1'b0, '0, '0, '0, 1'b1, 12'h000, 1'b0, 12'hFFF);
      idle(); idle();
      chk("R9 pending", 32'(req_rd), 32'h002);
      chk("R9 line low", 32'(irq_line), 0);

      // R8/R11 single-source sweep
      for (int s = 0; s < 12; s++) begin
         clear_all();
         cyc(12'(1 << s), 1'b0, '0, '0, '0, 1'b1, 12'(1 << s), 1'b0, 12'hFFF);
         idle();
         chk("R8 single source", 32'(irq_line), 32'(grp(12'(1 << s))));
         chk("R11 single id", 32'(irq_src_id), s);
      end

      // R10 acknowledge pulses line low, then restores
      clear_all();
      cyc(12'h00C, 1'b0, '0, '0, '0, 1'b1, 12'hFFF, 1'b0, 12'hFFF);
      idle();
      chk("R10 line up", 32'(irq_line), 32'h4);
      cyc('0, 1'b0, '0, '0, '0, 1'b0, '0, 1'b1, 12'hFF7);
      chk("R10 acked low", 32'(irq_line), 0);
      idle();
      chk("R10 restored", 32'(irq_line), 32'h4);

      // R8/R11 every pending pattern with everything enabled
      for (int p = 1; p < 4096; p++) begin
         clear_all();
         cyc(12'(p), 1'b0, '0, '0, '0, 1'b0, '0, 1'b0, 12'hFFF);
         idle();
         chk("R8 pattern lines", 32'(irq_line), 32'(grp(12'(p))));
         chk("R11 pattern id", 32'(irq_src_id), 32'(lowest(12'(p))));
      end

      // mixed traffic against the cycle model
      for (int i = 0; i < 3000; i++) begin
         logic [11:0] e;
         e = ($urandom % 4 == 0) ? 12'(1 << ($urandom % 12)) : 12'h000;
         cyc(e, ($urandom % 3 == 0), ($urandom % 2) ? 10'($urandom % 4 * 128) : 10'($urandom),
             4'($urandom % 16 & $urandom % 16), 4'($urandom % 16 & $urandom % 16),
             ($urandom % 10 == 0), 12'($urandom),
             ($urandom % 6 == 0), 12'($urandom) | 12'($urandom));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule